// File: doc/BRIEF.md
# Serial Flash Status and Write-Enable Controller

This block is the configuration engine of a serial NOR flash slave. A front end that deserialises the serial bus hands it each decoded opcode, each received data byte and, when chip select rises, the number of data bits that followed the opcode. The block keeps the 16-bit status word, the write-enable latch and the busy flag, and returns the status byte that the front end shifts out during a status read.

The status word exists twice: a non-volatile copy that survives a device reset and an active (volatile) copy that drives all behaviour and all reads. A status write normally goes through a self-timed cycle that is modelled with a counter. When it ends, both copies are updated and the write-enable latch drops. A dedicated opcode instead routes the next status write straight into the active copy, with no busy time. A device reset reloads the active copy from the non-volatile one. A separate power-on reset puts the non-volatile copy at its factory value.

Status bit map used throughout: S0 busy, S1 write-enable latch, S2..S6 protect-area bits, S7 protect-lock-low, S8 protect-lock-high, S9 quad-enable, S10..S13 general, S14 complement, S15 reserved.

Top module: `sfc_status_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low) both status copies equal `NV_DEFAULT` in S15..S2, and the latch and busy flag are 0, so both status bytes read as that value with S1=S0=0.
- R2: While not busy, opcode 0x06 sets the write-enable latch (S1) and opcode 0x04 clears it.
- R3: While opcode 0x05 is the active frame `rd_byte` is S7..S0, and while 0x35 is active it is S15..S8. The value stays valid for as long as chip select stays low, and it can be read while busy. With no read frame active, `rd_byte` is 0x00.
- R4: A status write (opcode 0x01) is ignored unless the latch is set or the instruction just before it was 0x50.
- R5: A status write executes only when `frame_bits` at chip-select rise is exactly 8 or 16. Any other count leaves all state unchanged.
- R6: A status write never alters S15, S1 or S0 from the data bytes. The first data byte supplies S7..S2 and the second byte supplies S14..S8.
- R7: An 8-bit status write clears S14, S9 and S8 and keeps S13..S10 and S15.
- R8: A non-volatile status write holds S0=1 for `TW_CYCLES` cycles starting the cycle after chip select rises, with the old status still visible. It then installs the new value in both copies and clears the latch.
- R9: Opcode 0x50 does not set the latch. It arms only the very next instruction: if that is 0x01, the new value goes to the active copy immediately, with no busy time, and the non-volatile copy is left unchanged. Any other instruction in between cancels it.
- R10: When S8=0, S7=1 and `wp_n` is low, status writes are ignored.
- R11: While busy, opcodes 0x06, 0x04, 0x01 and 0x50 are ignored.
- R12: Device reset (`rst_n` low) reloads the active copy from the non-volatile copy and clears the latch, the busy flag and any 0x50 arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; loads factory status |
| rst_n | input | 1 | Device reset, active low, synchronous |
| op_valid | input | 1 | One-cycle pulse: opcode received |
| op_code | input | 8 | Decoded opcode |
| byte_valid | input | 1 | One-cycle pulse: data byte received |
| byte_in | input | 8 | Received data byte |
| cs_rise | input | 1 | One-cycle pulse: chip select went high |
| frame_bits | input | BITCNT_W | Data bits received after the opcode, valid with `cs_rise` |
| wp_n | input | 1 | Write-protect pin, active low |
| rd_byte | output | 8 | Status byte to shift out |

## Verification
The embedded properties assume the front end behaves like a real serial front end. Each frame starts with exactly one `op_valid`, its data bytes come after it, and it ends with one `cs_rise`. None of these pulses ever shares a cycle with another, and `frame_bits` carries a meaningful value only when `cs_rise` is high. The bench builds every frame through the same three tasks, one for the opcode, one for each data byte and one for the close. It drives `wp_n` only between frames. Outside the directed busy-window checks it waits out each self-timed cycle before starting the next frame, so the random phase never overlaps instructions with a cycle in progress.

// File: rtl/sfc_pkg.sv
// Shared constants for the serial flash status controller.
// Assumes a 16-bit status word with S0 = busy and S1 = write-enable latch.
package sfc_pkg;
    localparam int SR_W = 16;

    localparam logic [7:0] OP_NONE    = 8'h00;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_WRDI    = 8'h04;
    localparam logic [7:0] OP_RDSR_LO = 8'h05;
    localparam logic [7:0] OP_RDSR_HI = 8'h35;
    localparam logic [7:0] OP_WRSR    = 8'h01;
    localparam logic [7:0] OP_VWREN   = 8'h50;

    localparam int BIT_LOCK_LO = 7;
    localparam int BIT_LOCK_HI = 8;

    // Bits no status write may take from data (reserved, latch, busy).
    localparam logic [SR_W-1:0] KEEP_MASK  = 16'h8003;
    // Bits an 8-bit status write forces to zero (complement, quad, lock-high).
    localparam logic [SR_W-1:0] SHORT_CLR  = 16'h4300;
endpackage

// File: rtl/sfc_frame_track.sv
// Frame tracker: remembers the opcode of the open frame, the first two data
// bytes, and whether a one-shot volatile arming applies to this frame.
// Assumes op_valid, byte_valid and cs_rise never coincide.
module sfc_frame_track
    import sfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    input  logic       cs_rise,
    input  logic       busy,
    output logic [7:0] cur_op,
    output logic [7:0] byte0,
    output logic [7:0] byte1,
    output logic       frame_vol
);
    logic armed_q;
    logic idx_q;

    // Track the open opcode; closes the frame on chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op <= OP_NONE;
        end else if (op_valid) begin
            cur_op <= op_code;
        end else if (cs_rise) begin
            cur_op <= OP_NONE;
        end
    end

    // Capture the first two data bytes of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 1'b0;
            byte0 <= '0;
            byte1 <= '0;
        end else if (op_valid) begin
            idx_q <= 1'b0;
        end else if (byte_valid) begin
            if (!idx_q) begin
                byte0 <= byte_in;
                idx_q <= 1'b1;
            end else begin
                byte1 <= byte_in;
            end
        end
    end

    // One-shot arming: set by the volatile-enable opcode, spent by the next opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            frame_vol <= 1'b0;
        end else if (op_valid) begin
            armed_q <= (op_code == OP_VWREN) && !busy;
            if (op_code == OP_WRSR) begin
                frame_vol <= armed_q;
            end
        end
    end
endmodule

// File: rtl/sfc_wr_merge.sv
// Write merge: forms the candidate status word S15..S2 from the current word
// and the frame's data bytes. Pure combinational; assumes data = {byte1, byte0}.
module sfc_wr_merge
    import sfc_pkg::*;
(
    input  logic [SR_W-1:2] cur,
    input  logic [SR_W-1:0] data,
    input  logic            short_frame,
    output logic [SR_W-1:2] merged
);
    logic unused_data;
    assign unused_data = ^data[1:0];

    // One rule per bit, picked from the package masks at elaboration.
    for (genvar i = 2; i < SR_W; i++) begin : g_bit
        if (KEEP_MASK[i]) begin : g_keep
            assign merged[i] = cur[i];
        end else if (i < 8) begin : g_low
            assign merged[i] = data[i];
        end else if (SHORT_CLR[i]) begin : g_clr
            assign merged[i] = short_frame ? 1'b0 : data[i];
        end else begin : g_hold
            assign merged[i] = short_frame ? cur[i] : data[i];
        end
    end
endmodule

// File: rtl/sfc_busy_timer.sv
// Self-timed cycle model: after start, busy stays high for TW_CYCLES cycles;
// done pulses in the last one. Assumes start only arrives while idle.
module sfc_busy_timer #(
    parameter int TW_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (TW_CYCLES > 2) ? $clog2(TW_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TW_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = busy && (cnt_q == '0);

    // Count down the cycle length while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= LAST;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LAST));
    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/sfc_status_ctrl.sv
// Status and write-enable controller of a serial NOR flash slave.
// Holds non-volatile and active status copies, the write-enable latch and
// the busy flag; returns the status byte for read frames.
// Assumes a front end that delivers opcode, data bytes and chip-select rise
// as separate one-cycle pulses.
module sfc_status_ctrl
    import sfc_pkg::*;
#(
    parameter int              TW_CYCLES  = 32,
    parameter int              BITCNT_W   = 6,
    parameter logic [SR_W-1:0] NV_DEFAULT = 16'h0000
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [7:0]          op_code,
    input  logic                byte_valid,
    input  logic [7:0]          byte_in,
    input  logic                cs_rise,
    input  logic [BITCNT_W-1:0] frame_bits,
    input  logic                wp_n,
    output logic [7:0]          rd_byte
);
    logic              any_rst_n;
    logic [7:0]        cur_op;
    logic [7:0]        byte0;
    logic [7:0]        byte1;
    logic              frame_vol;
    logic              busy;
    logic              tmr_done;
    logic              tmr_start;
    logic [SR_W-1:2]   vol_q;
    logic [SR_W-1:2]   nv_q;
    logic [SR_W-1:2]   pend_q;
    logic [SR_W-1:2]   merged;
    logic              wel_q;
    logic              hw_prot;
    logic              len_ok;
    logic              wr_ok;
    logic              vol_go;
    logic [SR_W-1:0]   status;

    assign any_rst_n = rst_n && por_n;

    sfc_frame_track u_track (
        .clk        (clk),
        .rst_n      (any_rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .cs_rise    (cs_rise),
        .busy       (busy),
        .cur_op     (cur_op),
        .byte0      (byte0),
        .byte1      (byte1),
        .frame_vol  (frame_vol)
    );

    sfc_wr_merge u_merge (
        .cur         (vol_q),
        .data        ({byte1, byte0}),
        .short_frame (frame_bits == BITCNT_W'(8)),
        .merged      (merged)
    );

    sfc_busy_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (any_rst_n),
        .start (tmr_start),
        .busy  (busy),
        .done  (tmr_done)
    );

    // Write acceptance at chip-select rise.
    always_comb begin
        hw_prot   = !vol_q[BIT_LOCK_HI] && vol_q[BIT_LOCK_LO] && !wp_n;
        len_ok    = (frame_bits == BITCNT_W'(8)) || (frame_bits == BITCNT_W'(16));
        wr_ok     = cs_rise && (cur_op == OP_WRSR) && !busy && !hw_prot
                    && (frame_vol || wel_q) && len_ok;
        vol_go    = wr_ok && frame_vol;
        tmr_start = wr_ok && !frame_vol;
    end

    // Non-volatile copy and the value waiting for the self-timed cycle.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            nv_q   <= NV_DEFAULT[SR_W-1:2];
            pend_q <= NV_DEFAULT[SR_W-1:2];
        end else begin
            if (tmr_start) begin
                pend_q <= merged;
            end
            if (tmr_done && rst_n) begin
                nv_q <= pend_q;
            end
        end
    end

    // Active copy: reloaded on reset, written directly or at cycle end.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            vol_q <= NV_DEFAULT[SR_W-1:2];
        end else if (!rst_n) begin
            vol_q <= nv_q;
        end else if (vol_go) begin
            vol_q <= merged;
        end else if (tmr_done) begin
            vol_q <= pend_q;
        end
    end

    // Write-enable latch: set/clear opcodes when idle, cleared at cycle end.
    always_ff @(posedge clk) begin
        if (!any_rst_n) begin
            wel_q <= 1'b0;
        end else if (tmr_done) begin
            wel_q <= 1'b0;
        end else if (op_valid && !busy) begin
            if (op_code == OP_WREN) begin
                wel_q <= 1'b1;
            end else if (op_code == OP_WRDI) begin
                wel_q <= 1'b0;
            end
        end
    end

    // Status byte for the open read frame.
    always_comb begin
        status = {vol_q, wel_q, busy};
        case (cur_op)
            OP_RDSR_LO: rd_byte = status[7:0];
            OP_RDSR_HI: rd_byte = status[15:8];
            default:    rd_byte = 8'h00;
        endcase
    end

    p_done_clears_wel_r8: assert property (@(posedge clk) disable iff (!any_rst_n)
        tmr_done |=> !wel_q);
    p_rsv_fixed_r6: assert property (@(posedge clk) disable iff (!any_rst_n)
        $stable(vol_q[SR_W-1]));
    p_vol_keeps_nv_r9: assert property (@(posedge clk) disable iff (!any_rst_n)
        vol_go |=> $stable(nv_q));
    p_busy_holds_wel_r11: assert property (@(posedge clk) disable iff (!any_rst_n)
        (busy && !tmr_done && op_valid) |=> (wel_q == $past(wel_q)));
    p_wren_sets_r2: assert property (@(posedge clk) disable iff (!any_rst_n)
        (op_valid && op_code == OP_WREN && !busy) |=> wel_q);
    p_protect_blocks_r10: assert property (@(posedge clk) disable iff (!any_rst_n)
        (cs_rise && hw_prot && !busy) |=> ($stable(vol_q) && !busy));
endmodule

// File: tb/tb_sfc_status_ctrl.sv
module tb_sfc_status_ctrl;
    localparam int TW = 32;
    localparam int BW = 6;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [7:0]    op_code = 8'h00;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_in = 8'h00;
    logic          cs_rise = 1'b0;
    logic [BW-1:0] frame_bits = '0;
    logic          wp_n = 1'b1;
    logic [7:0]    rd_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:2] exp_vol, exp_nv, exp_pend;
    logic        exp_wel, exp_arm;

    always #4 clk = ~clk;

    sfc_status_ctrl #(.TW_CYCLES(TW), .BITCNT_W(BW), .NV_DEFAULT(16'h0000)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .op_valid(op_valid),
        .op_code(op_code), .byte_valid(byte_valid), .byte_in(byte_in),
        .cs_rise(cs_rise), .frame_bits(frame_bits), .wp_n(wp_n), .rd_byte(rd_byte)
    );

    function automatic logic [15:2] mdl_merge(input logic [15:2] cur, input logic [7:0] b0,
                                              input logic [7:0] b1, input bit short);
        logic [15:2] r;
        r = cur;
        r[7:2] = b0[7:2];
        if (short) begin
            r[8] = 1'b0; r[9] = 1'b0; r[14] = 1'b0;
        end else begin
            r[14:8] = b1[6:0];
        end
        return r;
    endfunction

    function automatic bit mdl_prot();
        return !exp_vol[8] && exp_vol[7] && !wp_n;
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic pulse_op(input logic [7:0] op);
        op_valid = 1'b1; op_code = op;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_valid = 1'b1; byte_in = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic end_frame(input int bits);
        cs_rise = 1'b1; frame_bits = BW'(bits);
        @(negedge clk);
        cs_rise = 1'b0; frame_bits = '0;
    endtask

    // Plain one-byte instruction, modelled.
    task automatic do_cmd(input logic [7:0] op);
        pulse_op(op);
        end_frame(0);
        if (op == 8'h06) exp_wel = 1'b1;
        if (op == 8'h04) exp_wel = 1'b0;
        exp_arm = (op == 8'h50);
    endtask

    // Read one status byte, hold chip select low a while, check it stays (R3).
    task automatic rd(input logic [7:0] op, output logic [7:0] v);
        logic [7:0] again;
        pulse_op(op);
        v = rd_byte;
        repeat (3) @(negedge clk);
        again = rd_byte;
        check("R3 continuous read", {8'h00, again}, {8'h00, v});
        end_frame(0);
        exp_arm = 1'b0;
    endtask

    task automatic chk_status(input string tag, input bit busy_exp);
        logic [7:0] lo, hi;
        rd(8'h05, lo);
        rd(8'h35, hi);
        check(tag, {hi, lo}, {exp_vol, exp_wel, busy_exp});
    endtask

    // Status write frame; waits out the self-timed cycle when wait_done is set.
    task automatic do_wrsr(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                           input bit wait_done);
        bit vol, go;
        vol = exp_arm; exp_arm = 1'b0;
        go = (vol || exp_wel) && !mdl_prot() && (nbits == 8 || nbits == 16);
        pulse_op(8'h01);
        if (nbits > 0) send_byte(b0);
        if (nbits > 8) send_byte(b1);
        end_frame(nbits);
        if (go) begin
            exp_pend = mdl_merge(exp_vol, b0, b1, nbits == 8);
            if (vol) begin
                exp_vol = exp_pend;
            end else if (wait_done) begin
                repeat (TW + 4) @(negedge clk);
                exp_nv = exp_pend; exp_vol = exp_pend; exp_wel = 1'b0;
            end
        end
    endtask

    task automatic dev_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_vol = exp_nv; exp_wel = 1'b0; exp_arm = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int r;
        r = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        exp_nv = '0; exp_vol = '0; exp_wel = 0; exp_arm = 0;

        // R1: reset state; idle output
        check("R1 idle rd_byte", {8'h00, rd_byte}, 16'h0000);
        chk_status("R1 reset status", 1'b0);

        // R2: latch set and clear
        do_cmd(8'h06); chk_status("R2 wren", 1'b0);
        do_cmd(8'h04); chk_status("R2 wrdi", 1'b0);

        // R4: no latch, no arming -> ignored
        do_wrsr(8'hFC, 8'h7F, 16, 1); chk_status("R4 write without latch", 1'b0);

        // R5: bad lengths ignored, latch kept
        do_cmd(8'h06);
        do_wrsr(8'hFC, 8'h7F, 12, 1); chk_status("R5 12-bit frame", 1'b0);
        do_wrsr(8'hFC, 8'h7F, 24, 1); chk_status("R5 24-bit frame", 1'b0);

        // R8/R11/R6: non-volatile write, busy window behaviour
        do_wrsr(8'h1C, 8'hFF, 16, 0);
        rd(8'h05, v);
        check("R8 busy visible, old value", {8'h00, v}, {8'h00, 6'h00, 2'b11});
        do_cmd(8'h04); exp_wel = 1'b1;
        rd(8'h05, v);
        check("R11 wrdi ignored while busy", {8'h00, v}, {8'h00, 6'h00, 2'b11});
        pulse_op(8'h01); send_byte(8'h40); send_byte(8'h00); end_frame(16);
        repeat (TW + 4) @(negedge clk);
        exp_nv = exp_pend; exp_vol = exp_pend; exp_wel = 1'b0;
        chk_status("R8 R11 R6 committed after cycle", 1'b0);

        // R7: 8-bit write clears S14, S9, S8
        do_cmd(8'h06);
        do_wrsr(8'h08, 8'h00, 8, 1);
        chk_status("R7 short write", 1'b0);
        check("R7 high byte", {8'h00, exp_vol[15:8]}, 16'h003C);

        // R10: lock with SRP0=1, SRP1=0
        do_cmd(8'h06); do_wrsr(8'h80, 8'h00, 8, 1);
        wp_n = 1'b0;
        do_cmd(8'h06); do_wrsr(8'h04, 8'h00, 16, 1);
        chk_status("R10 protected write ignored", 1'b0);
        wp_n = 1'b1;
        do_wrsr(8'h04, 8'h00, 16, 1);
        chk_status("R10 unprotected write", 1'b0);

        // R9: volatile write, then reset reload (R12), then arming cancelled
        do_cmd(8'h50);
        do_wrsr(8'h20, 8'h05, 16, 0);
        chk_status("R9 volatile write immediate", 1'b0);
        dev_reset();
        chk_status("R12 reload from non-volatile", 1'b0);
        do_cmd(8'h50);
        rd(8'h05, v);
        do_wrsr(8'hF0, 8'h00, 16, 1);
        chk_status("R9 arming spent by read", 1'b0);

        // R1: power-on again restores factory value
        por_n = 1'b0; repeat (2) @(negedge clk); por_n = 1'b1; @(negedge clk);
        exp_nv = '0; exp_vol = '0; exp_wel = 0; exp_arm = 0;
        chk_status("R1 power-on restore", 1'b0);

        // Random phase
        for (int i = 0; i < 150; i++) begin
            wp_n = 1'($urandom % 2);
            r = int'($urandom % 8);
            case (r)
                0: do_cmd(8'h06);
                1: do_cmd(8'h04);
                2, 3, 4: begin
                    int nb;
                    nb = (($urandom % 4) == 0) ? 12 : ((($urandom % 2) == 0) ? 8 : 16);
                    if (($urandom % 2) == 0) do_cmd(8'h06);
                    do_wrsr(8'($urandom), 8'($urandom), nb, 1);
                end
                5: begin
                    do_cmd(8'h50);
                    do_wrsr(8'($urandom), 8'($urandom), 16, 1);
                end
                6: dev_reset();
                default: ;
            endcase
            chk_status("R2 R4 R5 R6 R7 R9 R10 R12 random", 1'b0);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule